// File: doc/BRIEF.md
# Unipolar Stepper Step/Direction Indexer

This block turns a step-and-direction command stream into the four phase-enable signals of a unipolar stepper motor. Every rising edge on the step input moves an internal position one place forward or backward through the excitation sequence of the selected mode. A translator then maps that position onto the four low-side phase outputs. Three excitation patterns are supported: two coils at a time (full step), alternating one and two coils (half step), and one coil at a time (wave drive).

The step, direction and mode inputs may come from another clock domain, so they pass through a synchronizer chain before use. Direction and mode are taken in the same cycle in which the step edge is detected. An active-low drive enable switches all phases off without disturbing the position. A fault-inhibit input blocks step edges while a fault is active. An active-low home flag reports when the position sits at the first entry of the sequence.

Top module: `stp_indexer`

## Requirements
- R1: `mode_in` selects the excitation: 2'b00 full step, 2'b01 half step, 2'b10 wave drive. The value 2'b11 is reserved.
- R2: In full step, with `phase_on[0]` as coil 1 through `phase_on[3]` as coil 4, positions 1..4 drive 4'b1001, 4'b0011, 4'b0110, 4'b1100.
- R3: In half step, positions 1..8 drive 4'b0001, 4'b0011, 4'b0010, 4'b0110, 4'b0100, 4'b1100, 4'b1000, 4'b1001.
- R4: In wave drive, positions 1..4 drive 4'b0001, 4'b0010, 4'b0100, 4'b1000.
- R5: Each accepted step edge moves the position by one. Direction high moves forward and direction low moves backward. The position wraps between the last position of the mode and position 1.
- R6: `home_n` is 0 exactly when the position is 1 and 1 at every other position. It does not depend on the enable.
- R7: `rst` (asynchronous, active high) returns the position to 1, and step edges seen while it is held have no effect.
- R8: While `drv_en_n` is 1, `phase_on` is 4'b0000. Step edges still move the position, and the moved position shows once the enable returns to 0.
- R9: A step edge detected while `fault_in` is 1 leaves the position unchanged.
- R10: With SYNC_STAGES synchronizer flops, a rise on `step_in` changes the position on rising clock edge SYNC_STAGES+1 after the rise, and not earlier. Direction and mode are taken from the same synchronized sample as the step edge.
- R11: On a change to full step, wave drive or the reserved mode, a half-step position p (1..8) becomes ((p-1) mod 4)+1 one cycle later. A four-position mode never indexes past position 4.
- R12: The reserved mode 2'b11 produces the same patterns and stepping as full step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous active-high reset |
| step_in | input | 1 | Step command; rising edge advances |
| dir_in | input | 1 | Direction: 1 forward, 0 backward |
| mode_in | input | 2 | Excitation mode select |
| drv_en_n | input | 1 | Active-low phase output enable |
| fault_in | input | 1 | Fault active; blocks step edges |
| phase_on | output | 4 | Phase-on signals, bit 0 = coil 1 |
| home_n | output | 1 | Active-low home position flag |

## Verification
The bench builds the block with SYNC_STAGES = 2. With that value the step-to-position delay is exactly three clock edges, so a directed case can check the cycle before the change and the cycle of the change. The default chain length also brings every mode, both wrap points, a mode change from a high half-step position, and enable and fault toggles between steps within reach of a few hundred random actions. A reference position model in the bench predicts the expected `phase_on` and `home_n` after every action.

// File: rtl/stp_pkg.sv
package stp_pkg;

  localparam int PHASES = 4;
  localparam int POS_W  = 3;

  typedef enum logic [1:0] {
    MODE_FULL = 2'b00,
    MODE_HALF = 2'b01,
    MODE_WAVE = 2'b10,
    MODE_RSVD = 2'b11
  } step_mode_e;

  // Only half step uses all eight positions.
  function automatic logic mode_is_half(input logic [1:0] m);
    return (m == MODE_HALF);
  endfunction

  // Index the translator uses: four-position modes see only the low bits.
  function automatic logic [POS_W-1:0] eff_index(input logic [1:0] m,
                                                 input logic [POS_W-1:0] p);
    return mode_is_half(m) ? p : {1'b0, p[1:0]};
  endfunction

  // Next position after one step in the given direction.
  function automatic logic [POS_W-1:0] next_pos(input logic [POS_W-1:0] p,
                                                input logic dir,
                                                input logic half);
    logic [POS_W-1:0] b;
    b = half ? p : {1'b0, p[1:0]};
    if (dir) b = b + 3'd1;
    else     b = b - 3'd1;
    if (!half) b[2] = 1'b0;
    return b;
  endfunction

  // Single-coil mask for coil k (0..3).
  function automatic logic [PHASES-1:0] coil(input logic [1:0] k);
    return 4'b0001 << k;
  endfunction

  // Coil pattern for a mode and position.
  function automatic logic [PHASES-1:0] coil_pattern(input logic [1:0] m,
                                                     input logic [POS_W-1:0] p);
    logic [1:0] k;
    logic [PHASES-1:0] pat;
    case (m)
      MODE_HALF: begin
        k   = p[2:1];
        pat = coil(k) | (p[0] ? coil(k + 2'd1) : 4'b0000);
      end
      MODE_WAVE: begin
        pat = coil(p[1:0]);
      end
      default: begin
        k   = p[1:0];
        pat = coil(k) | coil(k - 2'd1);
      end
    endcase
    return pat;
  endfunction

endpackage

// File: rtl/stp_sync.sv
module stp_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/stp_edge.sv
module stp_edge (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic rise
);

  logic level_d;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) level_d <= 1'b0;
    else     level_d <= level;
  end

  assign rise = level & ~level_d;

endmodule

// File: rtl/stp_pos_counter.sv
module stp_pos_counter
  import stp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             step_evt,
  input  logic             dir,
  input  logic [1:0]       mode,
  output logic [POS_W-1:0] pos
);

  logic half_w;
  assign half_w = mode_is_half(mode);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      pos <= '0;
    end else if (step_evt) begin
      pos <= next_pos(pos, dir, half_w);
    end else if (!half_w && pos[2]) begin
      pos <= {1'b0, pos[1:0]};
    end
  end

endmodule

// File: rtl/stp_translator.sv
module stp_translator
  import stp_pkg::*;
(
  input  logic [1:0]        mode,
  input  logic [POS_W-1:0]  pos,
  input  logic              drv_en_n,
  output logic [PHASES-1:0] phase_on,
  output logic              home_n
);

  logic [POS_W-1:0]  idx_w;
  logic [PHASES-1:0] pat_w;

  assign idx_w  = eff_index(mode, pos);
  assign pat_w  = coil_pattern(mode, idx_w);
  assign home_n = (idx_w != '0);

  for (genvar i = 0; i < PHASES; i++) begin : g_gate
    assign phase_on[i] = pat_w[i] & ~drv_en_n;
  end

endmodule

// File: rtl/stp_indexer.sv
module stp_indexer
  import stp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       step_in,
  input  logic       dir_in,
  input  logic [1:0] mode_in,
  input  logic       drv_en_n,
  input  logic       fault_in,
  output logic [3:0] phase_on,
  output logic       home_n
);

  localparam int SYNC_W = 4;

  logic [SYNC_W-1:0] raw_w;
  logic [SYNC_W-1:0] sync_w;
  logic              step_s;
  logic              dir_s;
  logic [1:0]        mode_s;
  logic              step_rise;
  logic              step_evt;
  logic [POS_W-1:0]  pos_q;

  assign raw_w = {mode_in, dir_in, step_in};

  stp_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_w),
    .q   (sync_w)
  );

  assign step_s = sync_w[0];
  assign dir_s  = sync_w[1];
  assign mode_s = sync_w[3:2];

  stp_edge u_edge (
    .clk   (clk),
    .rst   (rst),
    .level (step_s),
    .rise  (step_rise)
  );

  assign step_evt = step_rise & ~fault_in;

  stp_pos_counter u_cnt (
    .clk      (clk),
    .rst      (rst),
    .step_evt (step_evt),
    .dir      (dir_s),
    .mode     (mode_s),
    .pos      (pos_q)
  );

  stp_translator u_xlat (
    .mode     (mode_s),
    .pos      (pos_q),
    .drv_en_n (drv_en_n),
    .phase_on (phase_on),
    .home_n   (home_n)
  );

endmodule

// File: rtl/stp_indexer_chk.sv
module stp_indexer_chk (
  input logic       clk,
  input logic       rst,
  input logic       step_rise,
  input logic       step_evt,
  input logic       dir_s,
  input logic [1:0] mode_s,
  input logic [2:0] pos_q,
  input logic       fault_in,
  input logic       drv_en_n,
  input logic [3:0] phase_on,
  input logic       home_n
);

  // R8: a disabled driver keeps every phase off
  p_disable_off_r8: assert property (@(posedge clk) disable iff (rst)
    drv_en_n |-> (phase_on == 4'b0000));

  // R6: home always energizes coil 1 when enabled
  p_home_coil1_r6: assert property (@(posedge clk) disable iff (rst)
    (!drv_en_n && !home_n) |-> phase_on[0]);

  // R9: a step edge under fault does not move the position
  p_fault_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (step_rise && fault_in && mode_s == 2'b01) |=> $stable(pos_q));

  // R11: four-position modes never keep a high index
  p_clamp_r11: assert property (@(posedge clk) disable iff (rst)
    (mode_s != 2'b01) |=> !pos_q[2]);

  // R4: wave drive energizes exactly one coil
  p_wave_single_r4: assert property (@(posedge clk) disable iff (rst)
    (!drv_en_n && mode_s == 2'b10) |-> ($countones(phase_on) == 1));

  // R5: forward half step advances by one, with natural wrap
  p_half_fwd_r5: assert property (@(posedge clk) disable iff (rst)
    (step_evt && dir_s && mode_s == 2'b01) |=> (pos_q == $past(pos_q) + 3'd1));

endmodule

bind stp_indexer stp_indexer_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .step_rise (step_rise),
  .step_evt  (step_evt),
  .dir_s     (dir_s),
  .mode_s    (mode_s),
  .pos_q     (pos_q),
  .fault_in  (fault_in),
  .drv_en_n  (drv_en_n),
  .phase_on  (phase_on),
  .home_n    (home_n)
);

// File: tb/stp_indexer_tb.sv
module stp_indexer_tb_top;

  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rst;
  logic       step_in;
  logic       dir_in;
  logic [1:0] mode_in;
  logic       drv_en_n;
  logic       fault_in;
  logic [3:0] phase_on;
  logic       home_n;

  always #5 clk = ~clk;

  stp_indexer #(.SYNC_STAGES(SYNC)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .step_in  (step_in),
    .dir_in   (dir_in),
    .mode_in  (mode_in),
    .drv_en_n (drv_en_n),
    .fault_in (fault_in),
    .phase_on (phase_on),
    .home_n   (home_n)
  );

  int         n_chk = 0;
  int         n_bad = 0;
  int         mpos;
  logic [1:0] mmode;
  logic       men_n;
  logic       done = 1'b0;

  function automatic logic [3:0] exp_pat(logic [1:0] m, int p, logic en_n);
    logic [3:0] r;
    if (en_n) return 4'b0000;
    if (m == 2'b01) begin
      case (p)
        0: r = 4'b0001; 1: r = 4'b0011; 2: r = 4'b0010; 3: r = 4'b0110;
        4: r = 4'b0100; 5: r = 4'b1100; 6: r = 4'b1000; default: r = 4'b1001;
      endcase
    end else if (m == 2'b10) begin
      case (p % 4)
        0: r = 4'b0001; 1: r = 4'b0010; 2: r = 4'b0100; default: r = 4'b1000;
      endcase
    end else begin
      case (p % 4)
        0: r = 4'b1001; 1: r = 4'b0011; 2: r = 4'b0110; default: r = 4'b1100;
      endcase
    end
    return r;
  endfunction

  task automatic check(input string tag);
    logic [4:0] exp_v, act_v;
    exp_v = {(mpos != 0), exp_pat(mmode, mpos, men_n)};
    act_v = {home_n, phase_on};
    n_chk++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s: {home_n,phase_on} actual=%b expected=%b (mode=%b pos=%0d)",
               tag, act_v, exp_v, mmode, mpos + 1);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_step(input logic d);
    if (mmode == 2'b01) mpos = (mpos + (d ? 1 : 7)) % 8;
    else                mpos = (mpos + (d ? 1 : 3)) % 4;
  endtask

  task automatic do_step(input logic d);
    @(negedge clk);
    dir_in = d;
    idle(3);
    step_in = 1'b1;
    idle(4);
    step_in = 1'b0;
    idle(4);
    if (!fault_in) model_step(d);
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    mode_in = m;
    mmode   = m;
    idle(4);
    if (m != 2'b01) mpos = mpos % 4;
  endtask

  task automatic set_en(input logic v);
    @(negedge clk);
    drv_en_n = v;
    men_n    = v;
    idle(1);
  endtask

  task automatic set_fault(input logic v);
    @(negedge clk);
    fault_in = v;
    idle(1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    idle(2);
    step_in = 1'b1;
    idle(3);
    step_in = 1'b0;
    idle(2);
    rst = 1'b0;
    mpos = 0;
    idle(4);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    int r;
    r = $urandom(32'h5eed_0017);
    rst = 1'b1; step_in = 1'b0; dir_in = 1'b1; mode_in = 2'b00;
    drv_en_n = 1'b0; fault_in = 1'b0;
    mmode = 2'b00; men_n = 1'b0; mpos = 0;
    idle(3);
    check("R7 reset state full step home");
    rst = 1'b0;
    idle(4);

    // R2 / R1 full step forward incl. wrap, then backward wrap (R5)
    for (int i = 0; i < 4; i++) begin
      do_step(1'b1);
      check("R1/R2 full step forward");
    end
    check("R5 forward wrap back to home");
    do_step(1'b0);
    check("R5 backward wrap from home to position 4");
    do_step(1'b1);
    check("R6 home flag after return");

    // R10 latency
    @(negedge clk);
    dir_in = 1'b1;
    idle(3);
    step_in = 1'b1;
    idle(SYNC);
    check("R10 no change before sync latency");
    idle(1);
    model_step(1'b1);
    check("R10 change on edge SYNC+1");
    step_in = 1'b0;
    idle(4);

    // R3 half step, both directions
    set_mode(2'b01);
    check("R1/R3 half step entry");
    for (int i = 0; i < 9; i++) begin
      do_step(1'b1);
      check("R3 half step forward");
    end
    for (int i = 0; i < 3; i++) begin
      do_step(1'b0);
      check("R3 half step backward");
    end

    // R11 clamp: move to half position 6 (index 5) then switch to wave
    while (mpos != 5) do_step(1'b1);
    check("R3 half position 6");
    set_mode(2'b10);
    check("R11 clamp to wave position 2");

    // R4 wave
    for (int i = 0; i < 5; i++) begin
      do_step(1'b1);
      check("R1/R4 wave drive forward");
    end

    // R12 reserved
    set_mode(2'b11);
    for (int i = 0; i < 5; i++) begin
      do_step(i % 2 == 0);
      check("R12 reserved mode as full step");
    end

    // R8 enable
    set_en(1'b1);
    check("R8 outputs off when disabled");
    do_step(1'b1);
    do_step(1'b1);
    check("R8 position counts while disabled");
    set_en(1'b0);
    check("R8 counted position shows after enable");

    // R9 fault
    set_fault(1'b1);
    do_step(1'b1);
    check("R9 step ignored under fault");
    set_fault(1'b0);
    do_step(1'b1);
    check("R9 step accepted after fault clears");

    // R7 reset with steps during reset
    set_mode(2'b01);
    do_step(1'b1);
    do_reset();
    check("R7 reset returns home, steps ignored while held");

    // Random mix
    for (int it = 0; it < 400; it++) begin
      r = $urandom_range(0, 99);
      if (r < 60) begin
        do_step(1'($urandom_range(0, 1)));
        check("R5 random step");
      end else if (r < 72) begin
        set_mode(2'($urandom_range(0, 3)));
        check("R11 random mode change");
      end else if (r < 82) begin
        set_en(~men_n);
        check("R8 random enable toggle");
      end else if (r < 92) begin
        set_fault(~fault_in);
        check("R9 random fault toggle");
      end else begin
        do_reset();
        check("R7 random reset");
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule